// File: doc/BRIEF.md
# One-time-programmable fuse array controller

This block sits between a simple CPU register bus and an array of one-time-programmable fuse rows. In the design, the rows are modelled as flops. Software first sets an access-enable bit in the mode register. It then loads a command code, a row address and one or two words of write data, and writes 1 to the start bit. It polls the status register until the done flag appears, and finally clears the start bit. Read data is left in one or two read-data registers.

Three kinds of operation are supported: reading a row, programming a row, and entering or leaving programming mode. Programming is locked until four program-enable commands have been run with an exact key sequence in the first write-data word.

A programmed row can only gain 1 bits. A program command is busy for a time that grows with the number of 1 bits being burnt in. The parameter `ROW_WORDS` selects a row of one 32-bit word or of two 32-bit words. The parameter `ROWS` sets the array depth.

Top module: `fuse_ctl`

## Requirements
- R1: After reset, every register reads 0. This covers mode, command, start, status, address, write data and read data. Every array row also holds 0.
- R2: Bit 0 of the mode register (0x00) gates access. While it is 0, bus writes to the command (0x04), start (0x08), address (0x28) and write-data (0x2c, 0x64) registers are ignored, so no command can start.
- R3: The command register keeps only bits [5:0] and the address register keeps only bits [15:0]. Upper bits that are written read back as 0.
- R4: A command starts when 1 is written to bit 0 of the start register while that bit is 0 and no command is busy. The operands are captured when the command starts. Status bit 1 (status register 0x0C) sets when the command completes. Writing 0 to the start bit clears both the start bit and status bit 1.
- R5: Status bit 1 rises exactly L cycles after the start write is accepted. L is 2 for the read (0x00), enable (0x02), disable (0x03) and any other code. For program (0x0A), L is 2 plus the number of 1 bits across all write-data words of the row.
- R6: The read command copies the addressed row into the read-data registers: word 0 goes to 0x10 and word 1 to 0x5c. An address of `ROWS` or more returns zeros.
- R7: The enable command (0x02) is run four times in a row with write-data word 0 (0x2c) equal to 0xf, 0x4, 0x8 and 0xd. At completion of the fourth, status bit 2 sets. Any value that does not match the expected next key returns the sequence to its first step.
- R8: The disable command (0x03) clears status bit 2 and restarts the key sequence.
- R9: A program command while status bit 2 is set makes the row equal to the old row OR the write data. While status bit 2 is clear, a program command still completes with done but leaves the row unchanged.
- R10: A start-clear write may be accepted on the same clock edge on which a command completes. In that case the operation still takes effect, and status bit 1 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_waddr | input | 8 | Byte offset of the register written |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | 8 | Byte offset of the register read |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |

## Verification
Two functions can meet in one cycle: the completion of a running command, and a software write that clears the start bit. The bench provokes this by counting the latency of a program command from its own bit count. It then times a start-clear write so that the write lands on the exact completion edge. The result is judged at the ports: status bit 1 must read 0 afterwards, and a later read of the row must show the programmed bits.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam int CMD_W  = 6;
  localparam int ADR_W  = 16;
  localparam int KEY_LEN = 4;

  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_START = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_RD0   = 8'h10;
  localparam logic [7:0] OFS_ADDR  = 8'h28;
  localparam logic [7:0] OFS_WD0   = 8'h2C;
  localparam logic [7:0] OFS_RD1   = 8'h5C;
  localparam logic [7:0] OFS_WD1   = 8'h64;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ = 6'h00,
    CMD_PEN  = 6'h02,
    CMD_PDIS = 6'h03,
    CMD_PROG = 6'h0A
  } fuse_cmd_e;

  // unlock key, step by step
  function automatic logic [31:0] unlock_key(input logic [1:0] step);
    case (step)
      2'd0:    return 32'h0000_000F;
      2'd1:    return 32'h0000_0004;
      2'd2:    return 32'h0000_0008;
      default: return 32'h0000_000D;
    endcase
  endfunction

  // register offsets of row words (word 0 or word 1)
  function automatic logic [7:0] wd_ofs(input int w);
    return (w == 0) ? OFS_WD0 : OFS_WD1;
  endfunction

  function automatic logic [7:0] rd_ofs(input int w);
    return (w == 0) ? OFS_RD0 : OFS_RD1;
  endfunction

endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
#(
  parameter int ROW_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [7:0]              rd_addr,
  input  logic                    done,
  input  logic                    prog_ok,
  input  logic [32*ROW_WORDS-1:0] rdata,
  output logic [31:0]             rd_data,
  output logic                    mode_en,
  output logic [CMD_W-1:0]        cmd,
  output logic [ADR_W-1:0]        addr,
  output logic [32*ROW_WORDS-1:0] wdata,
  output logic                    start_req,
  output logic                    start_clr
);

  logic             mode_q, mode_d;
  logic             start_q, start_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [ADR_W-1:0] addr_q, addr_d;
  logic [31:0]      wd_q [ROW_WORDS];
  logic [ROW_WORDS-1:0] wd_hit;

  logic acc, hit_mode, hit_cmd, hit_start, hit_addr;

  assign acc       = wr_en && mode_q;
  assign hit_mode  = wr_en && (wr_addr == OFS_MODE);
  assign hit_cmd   = acc && (wr_addr == OFS_CMD);
  assign hit_start = acc && (wr_addr == OFS_START);
  assign hit_addr  = acc && (wr_addr == OFS_ADDR);

  assign start_req = hit_start && wr_data[0] && !start_q;
  assign start_clr = hit_start && !wr_data[0];

  always_comb begin
    mode_d  = hit_mode  ? wr_data[0]            : mode_q;
    start_d = hit_start ? wr_data[0]            : start_q;
    cmd_d   = hit_cmd   ? wr_data[CMD_W-1:0]    : cmd_q;
    addr_d  = hit_addr  ? wr_data[ADR_W-1:0]    : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      start_q <= start_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
    end
  end

  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_wd
    assign wd_hit[g] = acc && (wr_addr == wd_ofs(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wd_q[g] <= '0;
      else if (wd_hit[g]) wd_q[g] <= wr_data;
    end
    assign wdata[32*g +: 32] = wd_q[g];
  end

  assign mode_en = mode_q;
  assign cmd     = cmd_q;
  assign addr    = addr_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_MODE:  rd_data = {31'b0, mode_q};
      OFS_CMD:   rd_data = {{(32-CMD_W){1'b0}}, cmd_q};
      OFS_START: rd_data = {31'b0, start_q};
      OFS_STAT:  rd_data = {29'b0, prog_ok, done, 1'b0};
      OFS_ADDR:  rd_data = {{(32-ADR_W){1'b0}}, addr_q};
      default:   rd_data = '0;
    endcase
    for (int w = 0; w < ROW_WORDS; w++) begin
      if (rd_addr == wd_ofs(w)) rd_data = wd_q[w];
      if (rd_addr == rd_ofs(w)) rd_data = rdata[32*w +: 32];
    end
  end

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int ROW_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_req,
  input  logic                    start_clr,
  input  logic [CMD_W-1:0]        cmd,
  input  logic [ADR_W-1:0]        addr,
  input  logic [32*ROW_WORDS-1:0] wdata,
  output logic                    busy,
  output logic                    done,
  output logic                    complete,
  output logic [CMD_W-1:0]        op_cmd,
  output logic [ADR_W-1:0]        op_addr,
  output logic [32*ROW_WORDS-1:0] op_wdata
);

  localparam int ROW_BITS = 32 * ROW_WORDS;
  localparam int LAT_MAX  = 2 + ROW_BITS;
  localparam int CNT_W    = $clog2(LAT_MAX + 1);

  function automatic logic [CNT_W-1:0] ones(input logic [ROW_BITS-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < ROW_BITS; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic [CNT_W-1:0]    cnt_q, cnt_d, lat;
  logic                done_q, done_d;
  logic                launch;
  logic [CMD_W-1:0]    cmd_q;
  logic [ADR_W-1:0]    addr_q;
  logic [ROW_BITS-1:0] wd_q;

  assign busy     = (cnt_q != '0);
  assign launch   = start_req && !busy;
  assign complete = (cnt_q == CNT_W'(1));

  always_comb begin
    lat = CNT_W'(2);
    if (cmd == CMD_PROG) lat = CNT_W'(2) + ones(wdata);
    if (launch)     cnt_d = lat;
    else if (busy)  cnt_d = cnt_q - CNT_W'(1);
    else            cnt_d = cnt_q;
    if (start_clr || launch) done_d = 1'b0;
    else if (complete)       done_d = 1'b1;
    else                     done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (launch) begin
      cmd_q  <= cmd;
      addr_q <= addr;
      wd_q   <= wdata;
    end
  end

  assign done     = done_q;
  assign op_cmd   = cmd_q;
  assign op_addr  = addr_q;
  assign op_wdata = wd_q;

endmodule

// File: rtl/fuse_unlock.sv
module fuse_unlock
  import fuse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             complete,
  input  logic [CMD_W-1:0] op_cmd,
  input  logic [31:0]      op_key,
  output logic             prog_ok
);

  localparam int IDX_W = $clog2(KEY_LEN);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ok_q, ok_d;
  logic             pen_done, pdis_done, key_match;

  assign pen_done  = complete && (op_cmd == CMD_PEN);
  assign pdis_done = complete && (op_cmd == CMD_PDIS);
  assign key_match = (op_key == unlock_key(idx_q));

  always_comb begin
    idx_d = idx_q;
    ok_d  = ok_q;
    if (pdis_done) begin
      idx_d = '0;
      ok_d  = 1'b0;
    end else if (pen_done) begin
      if (!key_match) begin
        idx_d = '0;
      end else if (idx_q == IDX_W'(KEY_LEN - 1)) begin
        idx_d = '0;
        ok_d  = 1'b1;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      ok_q  <= ok_d;
    end
  end

  assign prog_ok = ok_q;

endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int ROW_WORDS = 2,
  parameter int ROWS      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    complete,
  input  logic [CMD_W-1:0]        op_cmd,
  input  logic [ADR_W-1:0]        op_addr,
  input  logic [32*ROW_WORDS-1:0] op_wdata,
  input  logic                    prog_ok,
  output logic [32*ROW_WORDS-1:0] rdata
);

  localparam int ROW_BITS = 32 * ROW_WORDS;

  logic [ROW_BITS-1:0] rows_q [ROWS];
  logic [ROWS-1:0]     row_we;
  logic [ROW_BITS-1:0] sel;
  logic [ROW_BITS-1:0] rd_q;
  logic                prog_we, rd_load;

  assign prog_we = complete && (op_cmd == CMD_PROG) && prog_ok;
  assign rd_load = complete && (op_cmd == CMD_READ);

  always_comb begin
    sel = '0;
    for (int i = 0; i < ROWS; i++) begin
      row_we[i] = prog_we && (op_addr == ADR_W'(i));
      if (op_addr == ADR_W'(i)) sel = rows_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) rows_q[i] <= '0;
    end else begin
      for (int i = 0; i < ROWS; i++)
        if (row_we[i]) rows_q[i] <= rows_q[i] | op_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= sel;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_pkg::*;
#(
  parameter int ROW_WORDS = 2,
  parameter int ROWS      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_waddr,
  input  logic [31:0] bus_wdata,
  input  logic [7:0]  bus_raddr,
  output logic [31:0] bus_rdata
);

  localparam int ROW_BITS = 32 * ROW_WORDS;

  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic                mode_en, start_req, start_clr;
  logic                busy, done, complete, prog_ok;
  logic [CMD_W-1:0]    cmd, op_cmd;
  logic [ADR_W-1:0]    addr, op_addr;
  logic [ROW_BITS-1:0] wdata, op_wdata, rdata;

  fuse_regs #(.ROW_WORDS(ROW_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(bus_wr), .wr_addr(bus_waddr), .wr_data(bus_wdata),
    .rd_addr(bus_raddr), .done(done), .prog_ok(prog_ok), .rdata(rdata),
    .rd_data(bus_rdata), .mode_en(mode_en), .cmd(cmd), .addr(addr),
    .wdata(wdata), .start_req(start_req), .start_clr(start_clr)
  );

  fuse_seq #(.ROW_WORDS(ROW_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .start_req(start_req), .start_clr(start_clr),
    .cmd(cmd), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .complete(complete),
    .op_cmd(op_cmd), .op_addr(op_addr), .op_wdata(op_wdata)
  );

  fuse_unlock u_unlock (
    .clk(clk), .rst_n(rst_core_n),
    .complete(complete), .op_cmd(op_cmd), .op_key(op_wdata[31:0]),
    .prog_ok(prog_ok)
  );

  fuse_array #(.ROW_WORDS(ROW_WORDS), .ROWS(ROWS)) u_array (
    .clk(clk), .rst_n(rst_core_n),
    .complete(complete), .op_cmd(op_cmd), .op_addr(op_addr),
    .op_wdata(op_wdata), .prog_ok(prog_ok), .rdata(rdata)
  );

endmodule

// File: rtl/fuse_ctl_chk.sv
module fuse_ctl_chk
  import fuse_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             complete,
  input logic [CMD_W-1:0] op_cmd,
  input logic             prog_ok,
  input logic             start_req,
  input logic             start_clr,
  input logic             mode_en
);

  // R4: done only appears at the end of a busy period
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R4: done drops only on a start-bit write
  a_r4_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start_clr || start_req));

  // R2: a command can begin only with access enabled
  a_r2_launch_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode_en));

  // R7: programming mode opens only on an enable-command completion
  a_r7_ok_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ok) |-> $past(complete && (op_cmd == CMD_PEN)));

  // R8: disable completion closes programming mode
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && (op_cmd == CMD_PDIS)) |=> !prog_ok);

endmodule

bind fuse_ctl fuse_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .busy(busy), .done(done),
  .complete(complete), .op_cmd(op_cmd), .prog_ok(prog_ok),
  .start_req(start_req), .start_clr(start_clr), .mode_en(mode_en)
);

// File: tb/sim_fuse_ctl.sv
module sim_fuse_ctl;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_waddr;
  logic [31:0] bus_wdata;
  logic [7:0]  bus_raddr;
  logic [31:0] bus_rdata;

  int checks;
  int failures;
  bit ended;

  fuse_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08,
                         A_STAT = 8'h0C, A_RD0 = 8'h10, A_ADDR = 8'h28,
                         A_WD0 = 8'h2C, A_RD1 = 8'h5C, A_WD1 = 8'h64;
  localparam logic [5:0] C_READ = 6'h00, C_PEN = 6'h02, C_PDIS = 6'h03,
                         C_PROG = 6'h0A;

  localparam int NV = 6;
  localparam logic [15:0] V_ADDR [NV] = '{16'd0, 16'd1, 16'd2, 16'd0, 16'd15, 16'd1};
  localparam logic [31:0] V_W0 [NV] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                                         32'h0000_00F0, 32'hA5A5_5A5A, 32'h0};
  localparam logic [31:0] V_W1 [NV] = '{32'h0, 32'hFFFF_FFFF, 32'h0000_0001,
                                         32'h1234_0000, 32'h0F0F_0000, 32'h0};

  logic [31:0] model0 [16];
  logic [31:0] model1 [16];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_raddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic setup(input logic [5:0] c, input logic [15:0] a,
                       input logic [31:0] w0, input logic [31:0] w1);
    bwr(A_CMD, {26'b0, c});
    bwr(A_ADDR, {16'b0, a});
    bwr(A_WD0, w0);
    bwr(A_WD1, w1);
  endtask

  // starts a command and returns cycles from start acceptance to done
  task automatic run(input logic [5:0] c, input logic [15:0] a,
                     input logic [31:0] w0, input logic [31:0] w1, output int lat);
    logic [31:0] s;
    setup(c, a, w0, w1);
    bwr(A_START, 32'h1);
    lat = 0;
    s = '0;
    while (!s[1] && lat < 300) begin
      brd(A_STAT, s);
      lat++;
    end
    bwr(A_START, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lat;
    checks = 0; failures = 0; ended = 0;
    bus_wr = 0; bus_waddr = 0; bus_wdata = 0; bus_raddr = 0;
    for (int i = 0; i < 16; i++) begin model0[i] = '0; model1[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    brd(A_STAT, d);  check("R1 status", d, 32'h0);
    brd(A_MODE, d);  check("R1 mode", d, 32'h0);
    brd(A_RD0, d);   check("R1 rdata0", d, 32'h0);

    // R2 access gate: writes ignored while mode bit 0 clear
    bwr(A_CMD, 32'h3F);
    bwr(A_WD0, 32'h1234_5678);
    bwr(A_START, 32'h1);
    repeat (5) @(negedge clk);
    brd(A_CMD, d);   check("R2 cmd ignored", d, 32'h0);
    brd(A_WD0, d);   check("R2 wdata ignored", d, 32'h0);
    brd(A_START, d); check("R2 start ignored", d, 32'h0);
    brd(A_STAT, d);  check("R2 no command ran", d, 32'h0);

    bwr(A_MODE, 32'h1);
    // R3 field widths
    bwr(A_CMD, 32'hFFFF_FFCA);
    brd(A_CMD, d);   check("R3 cmd masked", d, 32'h0000_000A);
    bwr(A_ADDR, 32'hABCD_0007);
    brd(A_ADDR, d);  check("R3 addr masked", d, 32'h0000_0007);

    // R9 locked program: done but no change, R5 latency 66
    run(C_PROG, 16'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, lat);
    check("R5 locked program latency", lat, 66);
    brd(A_STAT, d);  check("R4 done cleared by start=0", d, 32'h0);
    run(C_READ, 16'd3, 0, 0, lat);
    check("R5 read latency", lat, 2);
    brd(A_RD0, d);   check("R9 locked row word0", d, 32'h0);
    brd(A_RD1, d);   check("R9 locked row word1", d, 32'h0);

    // R7 unlock with an error mid-sequence
    run(C_PEN, 0, 32'hF, 0, lat);
    check("R5 enable latency", lat, 2);
    run(C_PEN, 0, 32'h4, 0, lat);
    run(C_PEN, 0, 32'h9, 0, lat);
    run(C_PEN, 0, 32'h8, 0, lat);
    run(C_PEN, 0, 32'hD, 0, lat);
    brd(A_STAT, d);  check("R7 wrong key keeps lock", d[2], 1'b0);
    run(C_PEN, 0, 32'hF, 0, lat);
    run(C_PEN, 0, 32'h4, 0, lat);
    run(C_PEN, 0, 32'h8, 0, lat);
    brd(A_STAT, d);  check("R7 three keys not enough", d[2], 1'b0);
    run(C_PEN, 0, 32'hD, 0, lat);
    brd(A_STAT, d);  check("R7 unlocked", d[2], 1'b1);

    // R5 R6 R9 vector table: program, then read back
    for (int v = 0; v < NV; v++) begin
      int ea;
      ea = int'(V_ADDR[v]);
      run(C_PROG, V_ADDR[v], V_W0[v], V_W1[v], lat);
      check($sformatf("R5 program latency v%0d", v), lat,
            2 + $countones(V_W0[v]) + $countones(V_W1[v]));
      model0[ea] = model0[ea] | V_W0[v];
      model1[ea] = model1[ea] | V_W1[v];
      run(C_READ, V_ADDR[v], 0, 0, lat);
      brd(A_RD0, d); check($sformatf("R9 R6 row word0 v%0d", v), d, model0[ea]);
      brd(A_RD1, d); check($sformatf("R9 R6 row word1 v%0d", v), d, model1[ea]);
    end

    // R6 out-of-range address reads zero
    run(C_READ, 16'd20, 0, 0, lat);
    brd(A_RD0, d);   check("R6 out of range word0", d, 32'h0);
    brd(A_RD1, d);   check("R6 out of range word1", d, 32'h0);

    // R10 start clear lands on completion edge (L = 2 + 2 = 4)
    setup(C_PROG, 16'd5, 32'h0000_0003, 32'h0);
    bwr(A_START, 32'h1);
    repeat (2) @(negedge clk);
    bwr(A_START, 32'h0);
    brd(A_STAT, d);  check("R10 done stays low", d[1], 1'b0);
    repeat (3) @(negedge clk);
    brd(A_STAT, d);  check("R10 done still low", d[1], 1'b0);
    run(C_READ, 16'd5, 0, 0, lat);
    brd(A_RD0, d);   check("R10 program took effect", d, 32'h0000_0003);

    // R8 disable, then program is blocked
    run(C_PDIS, 0, 0, 0, lat);
    brd(A_STAT, d);  check("R8 disable clears ok", d[2], 1'b0);
    run(C_PROG, 16'd6, 32'hFF, 32'hFF, lat);
    run(C_READ, 16'd6, 0, 0, lat);
    brd(A_RD0, d);   check("R8 R9 row unchanged after disable", d, 32'h0);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule